// File: doc/BRIEF.md
# Frame-Synchronous Monitor Channel Master

This block is the controlling end of a low-rate control channel carried in one time slot of a TDM frame. Exactly one byte moves per frame in each direction, with no acknowledge. A host fills a 16-byte buffer with a message and selects the subscriber slot and the line mode. It then issues a start. The block sends the buffered bytes downstream, one per frame, at the addressed slot. Afterwards it listens on the upstream side and stores every non-idle reply byte in the same buffer. The host reads the replies back once the block is no longer busy.

Outgoing and incoming bytes share one buffer, so a transfer always has two phases: a send phase, then a receive phase. When the downstream side has nothing to send it carries the idle value 0xFF. Line timing arrives on a slot-strobe and slot-number input pair from an external frame counter. The block supports two line modes. In separate-line mode the reply is sampled on the upstream line in the transmit slot. In shared-line mode a single bidirectional line is used: the first half of the frame carries downstream data and the second half carries upstream data, so the reply is taken four slots after the transmit slot. If the host selects the handshaked protocol, the block reports it as unsupported and does nothing.

Top module: `mon_chan_master`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `count` are 0 and `ds_byte` is 0xFF.
- R2: While `busy` is 0, `ds_byte` is 0xFF.
- R3: After `start`, the bytes written by the host are sent in write order, one per frame. Each byte is presented on `ds_byte` with `ds_drive` high during the strobe of the transmit slot. No other byte is ever driven.
- R4: The transmit slot is `slot_addr` in separate-line mode (`cfg_shared`=0). In shared-line mode (`cfg_shared`=1) it is `slot_addr` with its top bit cleared. `ds_drive` is high at no other slot.
- R5: In the receive phase, `up_byte` is sampled at the transmit slot in separate-line mode and at the transmit slot plus 4 in shared-line mode. Non-FF values at any other slot are not stored.
- R6: A received 0xFF is treated as idle and is not stored.
- R7: Received non-FF bytes are stored in arrival order. After the transfer the host reads them through `rd_en`/`rd_data`, and `count` reports how many are held.
- R8: A non-FF byte that arrives while 16 bytes are held is dropped, and `overflow` is set. `overflow` stays set until the next accepted `start`, and `count` never exceeds 16.
- R9: The receive phase ends at the `rx_timeout`-th consecutive idle sample, where a value of 0 acts as 1. At that point `busy` falls and `done` pulses for one cycle. A start with an empty buffer goes straight to the receive phase.
- R10: When `cfg_hs`=1, `unsupported` is 1 and `start` is ignored.
- R11: While `busy` is 1, host writes, host reads and further starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shared | input | 1 | 1 selects shared-line mode, 0 separate-line mode |
| cfg_hs | input | 1 | 1 requests the handshaked protocol (unsupported) |
| slot_addr | input | 3 | Subscriber slot address |
| rx_timeout | input | 8 | Idle samples that end the receive phase |
| slot_stb | input | 1 | One-cycle strobe per time slot |
| slot_num | input | 3 | Number of the current slot, valid with `slot_stb` |
| ds_byte | output | 8 | Downstream byte |
| ds_drive | output | 1 | High when `ds_byte` is to be placed on the line this slot |
| up_byte | input | 8 | Upstream byte, valid with `slot_stb` |
| start | input | 1 | Begin a transfer |
| wr_en | input | 1 | Host write to the buffer |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read (pop) from the buffer |
| rd_data | output | 8 | Oldest byte in the buffer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| count | output | 5 | Bytes held in the buffer |
| overflow | output | 1 | A received byte was dropped because the buffer was full |
| unsupported | output | 1 | Handshaked protocol requested |

## Verification
The assertions assume that `slot_stb` is a single-cycle pulse and that `slot_num` and `up_byte` are valid together with it. They also assume that mode, address and timeout stay constant while `busy` is high. The bench produces frames of eight strobes, each followed by a gap cycle. It changes configuration only between transfers, and in shared-line mode it uses an address in the lower half of the frame. Reply bytes are placed only in the frames after the one that carried the request, and decoy bytes are put in slots that must not be sampled.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TX   = 2'd1,
    PH_RX   = 2'd2
  } phase_t;
endpackage

// File: rtl/mcm_fifo.sv
module mcm_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/mcm_slot_map.sv
module mcm_slot_map #(
  parameter int SLOT_W = 3
) (
  input  logic              cfg_shared,
  input  logic [SLOT_W-1:0] slot_addr,
  input  logic              slot_stb,
  input  logic [SLOT_W-1:0] slot_num,
  output logic              tx_hit,
  output logic              rx_hit
);
  logic [SLOT_W-1:0] tx_slot, rx_slot;

  // Shared line: the lower half of the frame is downstream, the upper half upstream.
  always_comb begin
    if (cfg_shared) begin
      tx_slot = {1'b0, slot_addr[SLOT_W-2:0]};
      rx_slot = {1'b1, slot_addr[SLOT_W-2:0]};
    end else begin
      tx_slot = slot_addr;
      rx_slot = slot_addr;
    end
  end

  assign tx_hit = slot_stb && (slot_num == tx_slot);
  assign rx_hit = slot_stb && (slot_num == rx_slot);
endmodule

// File: rtl/mcm_ctrl.sv
module mcm_ctrl
  import mcm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int TO_W  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_hs,
  input  logic [TO_W-1:0] rx_timeout,
  input  logic          tx_hit,
  input  logic          rx_hit,
  input  logic [DW-1:0] up_byte,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [CW-1:0] fifo_count,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic [DW-1:0] fifo_wdata,
  output phase_t        phase,
  output logic          done,
  output logic          overflow
);
  phase_t          state_q, state_d;
  logic [TO_W-1:0] idle_q, idle_d;
  logic            ovf_q, ovf_d;
  logic            done_q, done_d;
  logic            host_push, host_pop, line_push, line_pop;
  logic            idle_end;

  assign idle_end = ({1'b0, idle_q} + {{TO_W{1'b0}}, 1'b1}) >= {1'b0, rx_timeout};

  always_comb begin
    state_d   = state_q;
    idle_d    = idle_q;
    ovf_d     = ovf_q;
    done_d    = 1'b0;
    host_push = 1'b0;
    host_pop  = 1'b0;
    line_push = 1'b0;
    line_pop  = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (start && !cfg_hs) begin
          state_d = fifo_empty ? PH_RX : PH_TX;
          idle_d  = '0;
          ovf_d   = 1'b0;
        end else begin
          host_push = wr_en && !fifo_full;
          host_pop  = rd_en && !fifo_empty;
        end
      end
      PH_TX: begin
        if (tx_hit) begin
          line_pop = 1'b1;
          if (fifo_count == CW'(1)) begin
            state_d = PH_RX;
            idle_d  = '0;
          end
        end
      end
      PH_RX: begin
        if (rx_hit) begin
          if (up_byte == '1) begin
            if (idle_end) begin
              state_d = PH_IDLE;
              done_d  = 1'b1;
            end else begin
              idle_d = idle_q + TO_W'(1);
            end
          end else begin
            idle_d = '0;
            if (fifo_full) ovf_d = 1'b1;
            else           line_push = 1'b1;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      idle_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  assign fifo_push  = host_push | line_push;
  assign fifo_pop   = host_pop | line_pop;
  assign fifo_wdata = line_push ? up_byte : wr_data;
  assign phase      = state_q;
  assign done       = done_q;
  assign overflow   = ovf_q;
endmodule

// File: rtl/mon_chan_master.sv
module mon_chan_master
  import mcm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int SLOT_W = 3,
  parameter int TO_W   = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_shared,
  input  logic              cfg_hs,
  input  logic [SLOT_W-1:0] slot_addr,
  input  logic [TO_W-1:0]   rx_timeout,
  input  logic              slot_stb,
  input  logic [SLOT_W-1:0] slot_num,
  output logic [DW-1:0]     ds_byte,
  output logic              ds_drive,
  input  logic [DW-1:0]     up_byte,
  input  logic              start,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     count,
  output logic              overflow,
  output logic              unsupported
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          tx_hit, rx_hit;
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0] fifo_wdata, fifo_rdata;
  phase_t        phase;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mcm_slot_map #(.SLOT_W(SLOT_W)) u_map (
    .cfg_shared (cfg_shared),
    .slot_addr  (slot_addr),
    .slot_stb   (slot_stb),
    .slot_num   (slot_num),
    .tx_hit     (tx_hit),
    .rx_hit     (rx_hit)
  );

  mcm_ctrl #(.DW(DW), .DEPTH(DEPTH), .TO_W(TO_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .cfg_hs     (cfg_hs),
    .rx_timeout (rx_timeout),
    .tx_hit     (tx_hit),
    .rx_hit     (rx_hit),
    .up_byte    (up_byte),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .fifo_count (count),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fifo_wdata (fifo_wdata),
    .phase      (phase),
    .done       (done),
    .overflow   (overflow)
  );

  mcm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata (fifo_wdata),
    .rdata (fifo_rdata),
    .count (count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign ds_byte     = (phase == PH_TX) ? fifo_rdata : '1;
  assign ds_drive    = tx_hit && (phase == PH_TX);
  assign rd_data     = fifo_rdata;
  assign busy        = (phase != PH_IDLE);
  assign unsupported = cfg_hs;
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_stb,
  input logic          ds_drive,
  input logic [DW-1:0] ds_byte,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] count,
  input logic          overflow,
  input logic          unsupported
);
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ds_byte == '1); // R2
  AST_DRIVE_IN_TX: assert property (@(posedge clk) disable iff (!rst_n) ds_drive |-> busy); // R3
  AST_DRIVE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ds_drive |-> slot_stb); // R4
  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R8
  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(overflow) |-> count == CW'(DEPTH)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_HS_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (unsupported && !busy) |=> !busy); // R10
  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (busy && !slot_stb) |=> $stable(count)); // R11
endmodule

bind mon_chan_master mcm_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_stb    (slot_stb),
  .ds_drive    (ds_drive),
  .ds_byte     (ds_byte),
  .busy        (busy),
  .done        (done),
  .count       (count),
  .overflow    (overflow),
  .unsupported (unsupported)
);

// File: tb/tb_mon_chan_master.sv
module tb_mon_chan_master;
  logic       clk;
  logic       rst_n;
  logic       cfg_shared, cfg_hs;
  logic [2:0] slot_addr;
  logic [7:0] rx_timeout;
  logic       slot_stb;
  logic [2:0] slot_num;
  logic [7:0] ds_byte;
  logic       ds_drive;
  logic [7:0] up_byte;
  logic       start, wr_en, rd_en;
  logic [7:0] wr_data, rd_data;
  logic       busy, done, overflow, unsupported;
  logic [4:0] count;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int exp_tx_slot = 0;
  logic [7:0] txq[$];
  logic [7:0] reply [8];

  mon_chan_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared), .cfg_hs(cfg_hs),
    .slot_addr(slot_addr), .rx_timeout(rx_timeout), .slot_stb(slot_stb),
    .slot_num(slot_num), .ds_byte(ds_byte), .ds_drive(ds_drive), .up_byte(up_byte),
    .start(start), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .busy(busy), .done(done), .count(count), .overflow(overflow), .unsupported(unsupported)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected downstream bytes as the design drives them.
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (slot_stb && rst_n) begin
      if (!busy) chk(ds_byte == 8'hFF, "R2 idle line", ds_byte, 8'hFF);
      if (ds_drive) begin
        chk(int'(slot_num) == exp_tx_slot, "R4 transmit slot", slot_num, exp_tx_slot);
        if (txq.size() == 0) chk(1'b0, "R3 unexpected byte", ds_byte, 8'hFF);
        else begin
          logic [7:0] e;
          e = txq.pop_front();
          chk(ds_byte == e, "R3 byte order", ds_byte, e);
        end
      end
    end
  end

  task automatic run_frame();
    for (int s = 0; s < 8; s++) begin
      @(posedge clk); #1;
      slot_num = 3'(s); slot_stb = 1'b1; up_byte = reply[s];
      @(posedge clk); #1;
      slot_stb = 1'b0; up_byte = 8'hFF;
    end
    for (int s = 0; s < 8; s++) reply[s] = 8'hFF;
  endtask

  task automatic host_write(input logic [7:0] b);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = b;
    @(posedge clk); #1; wr_en = 1'b0;
    txq.push_back(b);
  endtask

  task automatic host_read(input logic [7:0] e, input string req);
    @(posedge clk); #1;
    chk(rd_data == e, req, rd_data, e);
    rd_en = 1'b1;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d0;
    logic [4:0] c0;
    rst_n = 1'b0; cfg_shared = 0; cfg_hs = 0; slot_addr = 0; rx_timeout = 8'd3;
    slot_stb = 0; slot_num = 0; up_byte = 8'hFF; start = 0; wr_en = 0; rd_en = 0; wr_data = 0;
    for (int s = 0; s < 8; s++) reply[s] = 8'hFF;
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(count == 0, "R1 count", count, 0);
    chk(ds_byte == 8'hFF, "R1 ds_byte", ds_byte, 8'hFF);

    // R10 handshaked mode refused
    cfg_hs = 1; #1;
    chk(unsupported == 1, "R10 unsupported", unsupported, 1);
    pulse_start();
    run_frame();
    chk(busy == 0, "R10 start ignored", busy, 0);
    cfg_hs = 0;

    // Separate-line mode, slot 5
    slot_addr = 3'd5; exp_tx_slot = 5; rx_timeout = 8'd3;
    host_write(8'hA5); host_write(8'h3C); host_write(8'h07);
    chk(count == 3, "R7 count after write", count, 3);
    pulse_start();
    chk(busy == 1, "R3 busy after start", busy, 1);
    run_frame(); run_frame(); run_frame();
    chk(txq.size() == 0, "R3 all bytes sent", txq.size(), 0);
    chk(busy == 1, "R9 in receive phase", busy, 1);
    reply[5] = 8'h11; reply[6] = 8'h77;
    run_frame();
    chk(count == 1, "R5 separate same slot", count, 1);
    c0 = count;
    @(posedge clk); #1; rd_en = 1; wr_en = 1; wr_data = 8'h55; start = 1;
    @(posedge clk); #1; rd_en = 0; wr_en = 0; start = 0;
    chk(count == c0, "R11 host access blocked", count, c0);
    run_frame();
    chk(count == 1, "R6 idle not stored", count, 1);
    reply[5] = 8'h22;
    run_frame();
    d0 = done_cnt;
    run_frame(); run_frame();
    chk(busy == 1, "R9 before timeout", busy, 1);
    run_frame();
    chk(busy == 0, "R9 timeout ends", busy, 0);
    chk(done_cnt == d0 + 1, "R9 single done", done_cnt, d0 + 1);
    chk(count == 2, "R7 stored count", count, 2);
    host_read(8'h11, "R7 first reply");
    host_read(8'h22, "R7 second reply");
    chk(count == 0, "R7 drained", count, 0);

    // Shared-line mode, slot 2 out, slot 6 in
    cfg_shared = 1; slot_addr = 3'd2; exp_tx_slot = 2;
    host_write(8'hC1); host_write(8'hC2);
    pulse_start();
    run_frame(); run_frame();
    chk(txq.size() == 0, "R4 shared sent", txq.size(), 0);
    reply[2] = 8'h99; reply[6] = 8'h33;
    run_frame();
    reply[6] = 8'h44;
    run_frame();
    run_frame(); run_frame();
    chk(busy == 1, "R9 shared before timeout", busy, 1);
    run_frame();
    chk(busy == 0, "R9 shared timeout", busy, 0);
    chk(count == 2, "R5 shared slot plus four", count, 2);
    host_read(8'h33, "R5 shared reply 1");
    host_read(8'h44, "R5 shared reply 2");

    // Overflow: empty start goes straight to receive
    cfg_shared = 0; slot_addr = 3'd1; exp_tx_slot = 1; rx_timeout = 8'd2;
    pulse_start();
    chk(busy == 1, "R9 empty start receives", busy, 1);
    for (int i = 0; i < 17; i++) begin
      reply[1] = 8'h40 + 8'(i);
      run_frame();
    end
    run_frame(); run_frame();
    chk(busy == 0, "R9 overflow run ended", busy, 0);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    chk(count == 16, "R8 count saturates", count, 16);
    for (int i = 0; i < 16; i++) host_read(8'h40 + 8'(i), "R8 kept bytes");
    chk(overflow == 1, "R8 overflow sticky", overflow, 1);
    pulse_start();
    chk(overflow == 0, "R8 cleared by start", overflow, 0);
    run_frame(); run_frame();
    chk(busy == 0, "R9 second timeout", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule